// File: doc/BRIEF.md
# Low-Power Retention and Wake Controller

This block sequences a real-time-clock domain into and out of a deep low-power state. A sleep request puts the domain to sleep, but only when the lock bit is clear. On entry the core clocks are gated and the lock bit is set in hardware. The lock freezes the pad states and the interrupt-enable register. Pending interrupt flags whose enable is clear are dropped. The time counter and the enable vector survive the stay. The general configuration register returns to its default value on wake-up.

While asleep, the crystal oscillator keeps running only when the RTC hold input is low. Any pending flag whose enable is set causes a wake-up, as does a rising edge on the wake pin. Wake-up drives a brown-out-style reset request for `RST_CYC` cycles, and the controller then returns to the active state. The lock stays set, and so does the flag that caused the exit. Software restores its settings, clears the lock, and then services the flag. Another sleep request is refused until the lock has been cleared.

Top module: `lpwake_ctrl`

## Requirements
- R1: After reset, `lock`, `bor_req` and `flag_q` are 0 and `clk_gate_en` and `osc_en` are 1. `ie_q` and `count_q` are 0 and `cfg_q` equals `CFG_DEF`.
- R2: A `sleep_req` sampled in the active state with `lock` at 0 enters sleep at that edge. From then on `clk_gate_en` is 0 and `lock` is 1.
- R3: On entry, each flag bit whose matching `ie_q` bit is 0 is cleared. Each flag bit whose enable is set is kept.
- R4: While asleep, `osc_en` equals the inverse of `rtc_hold`. In every state, `count_q` advances by one on each `tick` edge taken with `rtc_hold` at 0, and holds while `rtc_hold` is 1.
- R5: While asleep, a flag bit set together with its enable bit causes wake-up at the next edge. The source bits are 0 for the time event, 1 for the alarm, 2 for the prescaler tick and 3 for the oscillator fault. A flag bit whose enable is clear causes no wake-up.
- R6: While asleep, a rising edge on `wake_pin` causes wake-up.
- R7: Wake-up holds `bor_req` high for exactly `RST_CYC` cycles, after which the block is active again. During the wake-up reset, `cfg_q` equals `CFG_DEF`. After it, `lock` is still 1, and `count_q`, `ie_q` and the causing flag are retained.
- R8: A `sleep_req` while `lock` is 1 is ignored. This includes a cycle in which `lock_clr` is also asserted.
- R9: `ie_we` is ignored while `lock` is 1. `cfg_we` is ignored outside the active state.
- R10: In the active state, `lock_clr` clears `lock`. A bit set in `flag_clr` clears the matching flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter the low-power state |
| rtc_hold | input | 1 | RTC hold; stops counting and, when asleep, the oscillator |
| lock_clr | input | 1 | Strobe that clears the lock bit |
| ie_wdata | input | N_SRC | Interrupt-enable write data |
| ie_we | input | 1 | Interrupt-enable write strobe |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_we | input | 1 | Configuration write strobe |
| evt_in | input | N_SRC | Raw wake-capable RTC events |
| flag_clr | input | N_SRC | Per-bit flag clear |
| wake_pin | input | 1 | External wake pin |
| tick | input | 1 | Counter advance pulse |
| lock | output | 1 | Lock bit; freezes pads and enables |
| bor_req | output | 1 | Wake reset request |
| clk_gate_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Oscillator enable |
| ie_q | output | N_SRC | Retained interrupt enables |
| flag_q | output | N_SRC | Interrupt flags |
| cfg_q | output | CFG_W | Non-retained configuration |
| count_q | output | CNT_W | Retained time counter |

## Verification
Two events can fall in the same cycle: the lock clear and a sleep request. The bench drives both strobes in one cycle while the lock is set. It then expects the clocks to stay enabled and the lock to read 0, and it expects a later, separate request to put the domain to sleep. Sleep entry and flag updates also share a cycle. The stimulus table loads pending flags under differing enable masks and compares the flags at the port right after entry with the enabled subset of those flags.

// File: rtl/lpwake_ctrl.sv
module lpwake_ctrl #(
  parameter int N_SRC = 4,
  parameter int CFG_W = 8,
  parameter logic [CFG_W-1:0] CFG_DEF = 8'hA5,
  parameter int CNT_W = 16,
  parameter int RST_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             rtc_hold,
  input  logic             lock_clr,
  input  logic [N_SRC-1:0] ie_wdata,
  input  logic             ie_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             cfg_we,
  input  logic [N_SRC-1:0] evt_in,
  input  logic [N_SRC-1:0] flag_clr,
  input  logic             wake_pin,
  input  logic             tick,
  output logic             lock,
  output logic             bor_req,
  output logic             clk_gate_en,
  output logic             osc_en,
  output logic [N_SRC-1:0] ie_q,
  output logic [N_SRC-1:0] flag_q,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CNT_W-1:0] count_q
);
  localparam int RC_W = $clog2(RST_CYC + 1);

  typedef enum logic [1:0] {ST_ACT, ST_SLP, ST_WRST} st_t;

  st_t             st_q;
  logic [RC_W-1:0] rc_q;
  logic            pin_d;
  logic [N_SRC-1:0] flag_d;

  wire active   = (st_q == ST_ACT);
  wire enter    = active & sleep_req & ~lock;
  wire pin_edge = wake_pin & ~pin_d;
  wire wake     = (st_q == ST_SLP) & ((|(flag_q & ie_q)) | pin_edge);

  assign bor_req     = (st_q == ST_WRST);
  assign clk_gate_en = (st_q != ST_SLP);
  assign osc_en      = (st_q != ST_SLP) | ~rtc_hold;

  always_comb begin
    flag_d = enter ? (flag_q & ie_q) : flag_q;
    flag_d = (flag_d & ~flag_clr) | evt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_ACT;
      rc_q <= '0;
    end else begin
      case (st_q)
        ST_ACT:  if (enter) st_q <= ST_SLP;
        ST_SLP:  if (wake) begin
                   st_q <= ST_WRST;
                   rc_q <= RC_W'(RST_CYC - 1);
                 end
        ST_WRST: if (rc_q == '0) st_q <= ST_ACT;
                 else rc_q <= rc_q - 1'b1;
        default: st_q <= ST_ACT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock    <= 1'b0;
      pin_d   <= 1'b0;
      ie_q    <= '0;
      flag_q  <= '0;
      cfg_q   <= CFG_DEF;
      count_q <= '0;
    end else begin
      pin_d  <= wake_pin;
      flag_q <= flag_d;
      if (enter) lock <= 1'b1;
      else if (active && lock_clr) lock <= 1'b0;
      if (ie_we && active && !lock) ie_q <= ie_wdata;
      if (wake) cfg_q <= CFG_DEF;
      else if (cfg_we && active) cfg_q <= cfg_wdata;
      if (tick && !rtc_hold) count_q <= count_q + 1'b1;
    end
  end
endmodule

module lpwake_ctrl_chk #(
  parameter int N_SRC = 4,
  parameter int CFG_W = 8,
  parameter logic [CFG_W-1:0] CFG_DEF = 8'hA5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rtc_hold,
  input logic             lock,
  input logic             bor_req,
  input logic             clk_gate_en,
  input logic             osc_en,
  input logic [N_SRC-1:0] ie_q,
  input logic [N_SRC-1:0] flag_q,
  input logic [CFG_W-1:0] cfg_q
);
  assert_sleep_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_gate_en |-> lock);
  assert_osc_follows_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_gate_en |-> (osc_en == !rtc_hold));
  assert_enabled_flag_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_gate_en && |(flag_q & ie_q)) |=> bor_req);
  assert_cfg_default_in_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bor_req |-> (cfg_q == CFG_DEF));
  assert_lock_after_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bor_req) |-> (lock && clk_gate_en));
  assert_no_reentry_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && clk_gate_en && !bor_req) |=> clk_gate_en);
  assert_ie_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(ie_q));
endmodule

bind lpwake_ctrl lpwake_ctrl_chk #(.N_SRC(N_SRC), .CFG_W(CFG_W), .CFG_DEF(CFG_DEF)) chk_i (
  .clk(clk), .rst_n(rst_n), .rtc_hold(rtc_hold), .lock(lock), .bor_req(bor_req),
  .clk_gate_en(clk_gate_en), .osc_en(osc_en), .ie_q(ie_q), .flag_q(flag_q), .cfg_q(cfg_q)
);

// File: tb/lpwake_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpwake_ctrl_tb_top;
  localparam int RST_CYC = 4;
  localparam logic [7:0] CFG_DEF = 8'hA5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sleep_req, rtc_hold, lock_clr, ie_we, cfg_we, wake_pin, tick;
  logic [3:0] ie_wdata, evt_in, flag_clr;
  logic [7:0] cfg_wdata;
  logic lock, bor_req, clk_gate_en, osc_en;
  logic [3:0] ie_q, flag_q;
  logic [7:0] cfg_q;
  logic [15:0] count_q;

  lpwake_ctrl #(.N_SRC(4), .CFG_W(8), .CFG_DEF(CFG_DEF), .CNT_W(16), .RST_CYC(RST_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .rtc_hold(rtc_hold), .lock_clr(lock_clr),
    .ie_wdata(ie_wdata), .ie_we(ie_we), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we),
    .evt_in(evt_in), .flag_clr(flag_clr), .wake_pin(wake_pin), .tick(tick),
    .lock(lock), .bor_req(bor_req), .clk_gate_en(clk_gate_en), .osc_en(osc_en),
    .ie_q(ie_q), .flag_q(flag_q), .cfg_q(cfg_q), .count_q(count_q)
  );

  // {ie, pending before entry, event while asleep, pin pulse, expect wake, expect flags}
  localparam logic [17:0] VEC [8] = '{
    {4'b0001, 4'b0000, 4'b0001, 1'b0, 1'b1, 4'b0001},
    {4'b0010, 4'b0000, 4'b0010, 1'b0, 1'b1, 4'b0010},
    {4'b0100, 4'b0000, 4'b0100, 1'b0, 1'b1, 4'b0100},
    {4'b1000, 4'b0000, 4'b1000, 1'b0, 1'b1, 4'b1000},
    {4'b0001, 4'b0000, 4'b0010, 1'b0, 1'b0, 4'b0010},
    {4'b0000, 4'b1111, 4'b0000, 1'b1, 1'b1, 4'b0000},
    {4'b0101, 4'b0111, 4'b0000, 1'b0, 1'b1, 4'b0101},
    {4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 4'b0000}
  };

  int total = 0, bad = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] cnt0;
    int n;
    rst_n = 0; sleep_req = 0; rtc_hold = 0; lock_clr = 0; ie_we = 0; cfg_we = 0;
    wake_pin = 0; tick = 0; ie_wdata = 0; evt_in = 0; flag_clr = 0; cfg_wdata = 0;
    cyc(3); rst_n = 1; cyc(1);

    check("R1 lock", lock, 0);
    check("R1 bor", bor_req, 0);
    check("R1 gate", clk_gate_en, 1);
    check("R1 osc", osc_en, 1);
    check("R1 flags", flag_q, 0);
    check("R1 ie", ie_q, 0);
    check("R1 cfg", cfg_q, CFG_DEF);
    check("R1 count", count_q, 0);

    for (int i = 0; i < 8; i++) begin
      lock_clr = 1; flag_clr = 4'hF; cyc(1); lock_clr = 0; flag_clr = 0;
      ie_wdata = VEC[i][17:14]; ie_we = 1; cyc(1); ie_we = 0;
      check("R9 ie write unlocked", ie_q, VEC[i][17:14]);
      evt_in = VEC[i][13:10]; cyc(1); evt_in = 0;
      sleep_req = 1; cyc(1); sleep_req = 0;
      check("R2 gate off", clk_gate_en, 0);
      check("R2 lock set", lock, 1);
      check("R3 flags on entry", flag_q, VEC[i][13:10] & VEC[i][17:14]);
      evt_in = VEC[i][9:6]; wake_pin = VEC[i][5]; cyc(1); evt_in = 0; wake_pin = 0;
      n = 0;
      repeat (10) begin if (bor_req) n++; cyc(1); end
      check("R5 R6 wake length", n, VEC[i][4] ? RST_CYC : 0);
      if (!VEC[i][4]) begin
        wake_pin = 1; cyc(1); wake_pin = 0; cyc(RST_CYC + 3);
      end
      check("R7 flags kept", flag_q, VEC[i][3:0]);
      check("R7 lock kept", lock, 1);
      check("R7 active", clk_gate_en, 1);
    end

    sleep_req = 1; cyc(1); sleep_req = 0;
    check("R8 locked request", clk_gate_en, 1);
    lock_clr = 1; sleep_req = 1; cyc(1); lock_clr = 0; sleep_req = 0;
    check("R8 same cycle clear", clk_gate_en, 1);
    check("R10 lock cleared", lock, 0);

    cfg_wdata = 8'h3C; cfg_we = 1; cyc(1); cfg_we = 0;
    check("R9 cfg write active", cfg_q, 8'h3C);
    ie_wdata = 0; ie_we = 1; cyc(1); ie_we = 0;
    sleep_req = 1; cyc(1); sleep_req = 0;
    check("R2 enter after clear", clk_gate_en, 0);
    cfg_wdata = 8'h5A; cfg_we = 1; ie_wdata = 4'hF; ie_we = 1; cyc(1); cfg_we = 0; ie_we = 0;
    check("R9 cfg ignored asleep", cfg_q, 8'h3C);
    check("R9 ie ignored locked", ie_q, 0);

    check("R4 osc on", osc_en, 1);
    cnt0 = count_q;
    tick = 1; cyc(3); tick = 0;
    check("R4 count runs", count_q, cnt0 + 3);
    rtc_hold = 1; cyc(1);
    check("R4 osc off", osc_en, 0);
    tick = 1; cyc(3); tick = 0;
    check("R4 count held", count_q, cnt0 + 3);
    rtc_hold = 0;

    wake_pin = 1; cyc(1); wake_pin = 0; cyc(RST_CYC + 3);
    check("R7 cfg default", cfg_q, CFG_DEF);
    check("R7 count retained", count_q, cnt0 + 3);
    check("R7 lock after wake", lock, 1);

    evt_in = 4'b0100; cyc(1); evt_in = 0;
    check("R10 flag set", flag_q, 4'b0100);
    flag_clr = 4'b0100; cyc(1); flag_clr = 0;
    check("R10 flag cleared", flag_q, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule